// File: doc/BRIEF.md
# Paired-prescaler timer tick generator

This block turns one fast master clock (60 MHz in the intended system) into six count-enable strobes, one for each timer channel. The channels are grouped in three pairs. Each pair shares an 8-bit programmable prescaler, and each channel then applies its own power-of-two post-divider. Every output pulse is one master-clock cycle wide. It marks the instant a downstream timer counter should advance.

Software sets the prescale values and the divider codes once, before the PWM timers start, and normally leaves them alone. If a setting does change, the affected counters start again from zero, so no shortened period ever reaches a timer. A channel's tick period is the prescale factor (register value plus one) times the channel's divide ratio.

Top module: `tick_chan_gen`

## Requirements
- R1: While `rst_n` is low every bit of `tick` is 0. Reset is applied asynchronously and is released through a two-flop synchronizer.
- R2: The prescale factor of a pair is its 8-bit field plus one. Field 0 divides by 1, and field 255 divides by 256.
- R3: Pair p (field `psc_cfg[8p+7:8p]`) drives channels 2p and 2p+1. A change of that field restarts both of those channels and leaves the other pairs' tick phase unchanged.
- R4: Channels 0 to 3 map select code 0,1,2,3,4 (field `div_sel[3c+2:3c]`) to a divide ratio of 2,4,8,16,32. Codes 5 to 7 also give 32.
- R5: Channels 4 and 5 map codes 0,1,2,3 to a ratio of 2,4,8,16. Codes 4 to 7 also give 16.
- R6: With settings held, a channel ticks every (prescale factor × ratio) cycles, and each tick is high for exactly one cycle.
- R7: Suppose a channel's prescale field or select field first differs from its previous value in cycle k. Then the channel does not tick in cycle k, its divider restarts at zero, and its next tick is the ratio-th prescaler pulse counted from cycle k+1. For a prescale change this is cycle k + factor × ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_cfg | input | 24 | Three 8-bit prescale fields, pair 0 in the low byte |
| div_sel | input | 18 | Six 3-bit divider select codes, channel 0 in the low bits |
| tick | output | 6 | One-cycle count-enable strobe per channel |

## Verification
The first pattern uses a different prescale value in each pair and a mix of in-range and out-of-range codes. This separates the shared prescaler path from the per-channel divide path, and it shows how each channel group clamps codes that are too large. A select-only change with a nonzero prescale confirms that the divider restarts while the prescaler phase carries on. A prescale change to the maximum value on one pair shows that the other pairs keep their phase. A final drop to a prescale of zero exercises the pass-through case. A raw select change that leaves the effective ratio the same still triggers a restart, which the expected schedule accounts for.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int PSC_W      = 8;
  localparam int SEL_W      = 3;
  localparam int N_PAIRS    = 3;
  localparam int FULL_MAX   = 4;
  localparam int SHORT_MAX  = 3;
  localparam int SHORT_FROM = 4;
endpackage

// File: rtl/shared_prescaler.sv
module shared_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] psc_i,
  output logic         pre_tick_o,
  output logic         restart_o
);
  logic [W-1:0] pc_q, pc_d;
  logic [W-1:0] psc_q;

  always_comb begin
    restart_o  = (psc_i != psc_q);
    pre_tick_o = (pc_q == psc_q) && !restart_o;
    if (restart_o)             pc_d = '0;
    else if (pc_q == psc_q)    pc_d = '0;
    else                       pc_d = pc_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      psc_q <= '0;
    end else begin
      pc_q  <= pc_d;
      psc_q <= psc_i;
    end
  end

  // R7: a new prescale value restarts the count from zero
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    restart_o |=> (pc_q == '0));
  // R2: the count never passes the registered terminal value
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_q <= psc_q);
endmodule

// File: rtl/chan_postdiv.sv
module chan_postdiv #(
  parameter int SEL_W    = 3,
  parameter int MAX_CODE = 4,
  parameter int CW       = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             pre_tick_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] eff;
  logic [CW:0]      lim_w;
  logic [CW-1:0]    lim;
  logic [CW-1:0]    dc_q, dc_d;
  logic             sel_chg;

  always_comb begin
    eff     = (sel_q > SEL_W'(MAX_CODE)) ? SEL_W'(MAX_CODE) : sel_q;
    lim_w   = ((CW+1)'(1) << (eff + SEL_W'(1))) - (CW+1)'(1);
    lim     = lim_w[CW-1:0];
    sel_chg = (sel_i != sel_q);
    tick_o  = pre_tick_i && !sel_chg && (dc_q == lim);
    if (restart_i || sel_chg)  dc_d = '0;
    else if (pre_tick_i)       dc_d = (dc_q == lim) ? '0 : dc_q + CW'(1);
    else                       dc_d = dc_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_q  <= '0;
      sel_q <= '0;
    end else begin
      dc_q  <= dc_d;
      sel_q <= sel_i;
    end
  end

  // R6: a strobe never lasts more than one cycle
  assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  // R3: a prescaler restart or new select clears the divider
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (restart_i || sel_chg) |=> (dc_q == '0));
  // R4: the divider count stays below the selected ratio
  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    dc_q <= lim);
endmodule

// File: rtl/tick_chan_gen.sv
module tick_chan_gen
  import tick_pkg::*;
#(
  parameter int PSC_WIDTH  = PSC_W,
  parameter int SEL_WIDTH  = SEL_W,
  parameter int PAIRS      = N_PAIRS,
  parameter int FULL_CODE  = FULL_MAX,
  parameter int SHORT_CODE = SHORT_MAX,
  parameter int SHORT_CH   = SHORT_FROM
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PAIRS*PSC_WIDTH-1:0]   psc_cfg,
  input  logic [2*PAIRS*SEL_WIDTH-1:0] div_sel,
  output logic [2*PAIRS-1:0]           tick
);
  localparam int N_CH = 2 * PAIRS;
  localparam int CW   = FULL_CODE + 1;

  logic rst_s1, rst_s2;
  logic [PAIRS-1:0] pre_tick, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    shared_prescaler #(.W(PSC_WIDTH)) u_psc (
      .clk        (clk),
      .rst_ni     (rst_s2),
      .psc_i      (psc_cfg[p*PSC_WIDTH +: PSC_WIDTH]),
      .pre_tick_o (pre_tick[p]),
      .restart_o  (restart[p])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    localparam int MAXC = (c >= SHORT_CH) ? SHORT_CODE : FULL_CODE;
    chan_postdiv #(.SEL_W(SEL_WIDTH), .MAX_CODE(MAXC), .CW(CW)) u_div (
      .clk        (clk),
      .rst_ni     (rst_s2),
      .pre_tick_i (pre_tick[c/2]),
      .restart_i  (restart[c/2]),
      .sel_i      (div_sel[c*SEL_WIDTH +: SEL_WIDTH]),
      .tick_o     (tick[c])
    );
  end

  // R1: no strobe while the synchronized reset is held
  always @(posedge clk) begin
    if (!rst_s2) begin
      assert_quiet_in_reset_R1: assert (tick == '0);
    end
  end
endmodule

// File: tb/tick_chan_gen_bench.sv
module tick_chan_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] psc_cfg;
  logic [17:0] div_sel;
  logic [5:0]  tick;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit armed    = 0;
  bit done     = 0;

  int exp_q [6][$];
  int cur_psc [3];
  int cur_sel [6];
  int nxt_psc [3];
  int nxt_sel [6];
  int rp      [3];
  int next_t  [6];
  int per     [6];
  string cur_req = "R1";

  tick_chan_gen u_tick_chan_gen (
    .clk(clk), .rst_n(rst_n), .psc_cfg(psc_cfg), .div_sel(div_sel), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ratio_of(int ch, int code);
    int m;
    m = (ch >= 4) ? 3 : 4;
    if (code > m) code = m;
    return 2 << code;
  endfunction

  function automatic int first_tick(int k, int r, int psc, int ratio);
    int pp, base, f;
    pp = psc + 1;
    base = r + psc;
    if (k + 1 <= base) f = base;
    else f = base + ((k + 1 - base + pp - 1) / pp) * pp;
    return f + (ratio - 1) * pp;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies a configuration and pushes the expected tick cycles
  task automatic apply(int win, string req);
    int k;
    bit aff;
    for (int c = 0; c < 6; c++)
      check(exp_q[c].size() == 0, cur_req, exp_q[c].size(), 0, "ticks missing before reconfig");
    cur_req = req;
    for (int p = 0; p < 3; p++) psc_cfg[p*8 +: 8] = 8'(nxt_psc[p]);
    for (int c = 0; c < 6; c++) div_sel[c*3 +: 3] = 3'(nxt_sel[c]);
    k = cyc;
    for (int p = 0; p < 3; p++)
      if (nxt_psc[p] != cur_psc[p]) rp[p] = k + 1;
    for (int c = 0; c < 6; c++) begin
      aff = (nxt_psc[c/2] != cur_psc[c/2]) || (nxt_sel[c] != cur_sel[c]);
      if (aff) begin
        per[c] = (nxt_psc[c/2] + 1) * ratio_of(c, nxt_sel[c]);
        next_t[c] = first_tick(k, rp[c/2], nxt_psc[c/2], ratio_of(c, nxt_sel[c]));
      end
      while (next_t[c] < k + win) begin
        exp_q[c].push_back(next_t[c]);
        next_t[c] += per[c];
      end
    end
    for (int p = 0; p < 3; p++) cur_psc[p] = nxt_psc[p];
    for (int c = 0; c < 6; c++) cur_sel[c] = nxt_sel[c];
    armed = 1;
    repeat (win) @(posedge clk);
    #1;
  endtask

  // monitor: pops expected tick cycles and compares
  always @(negedge clk) begin
    if (armed) begin
      for (int c = 0; c < 6; c++) begin
        if (tick[c]) begin
          if (exp_q[c].size() == 0) begin
            check(0, cur_req, cyc, -1, $sformatf("unexpected tick ch%0d", c));
          end else begin
            int t;
            t = exp_q[c].pop_front();
            check(t == cyc, cur_req, cyc, t, $sformatf("tick cycle ch%0d", c));
          end
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    psc_cfg = '0;
    div_sel = '0;
    for (int p = 0; p < 3; p++) begin cur_psc[p] = 0; rp[p] = 0; end
    for (int c = 0; c < 6; c++) begin cur_sel[c] = 0; next_t[c] = 0; per[c] = 2; end
    repeat (3) begin
      @(negedge clk);
      check(tick == 6'b0, "R1", int'(tick), 0, "tick during reset");
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    // A: distinct prescalers, clamped codes on both channel groups
    nxt_psc = '{2, 0, 1};
    nxt_sel = '{0, 4, 7, 1, 3, 6};
    apply(400, "R4 R5 R6");
    // B: select-only change under a running prescaler
    nxt_sel[0] = 2;
    apply(300, "R7");
    // C: maximum prescale on pair 2, other pairs keep phase
    nxt_psc[2] = 255;
    nxt_sel[4] = 0;
    nxt_sel[5] = 5;
    apply(1200, "R2 R3");
    // D: pass-through prescale, raw code change with same ratio
    nxt_psc[0] = 0;
    nxt_sel[0] = 0;
    nxt_sel[5] = 4;
    apply(200, "R2 R7");
    for (int c = 0; c < 6; c++)
      check(exp_q[c].size() == 0, cur_req, exp_q[c].size(), 0, "ticks missing at end");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule